// File: doc/BRIEF.md
# Switch Memory Command Sequencer

This block sits between the queue logic of a cell switch and a shared cell memory. It turns one request at a time into a fixed series of commands on a 6-bit command bus. The data that belongs to each command travels on a separate 32-bit data bus, always one clock cycle after the command. Requests use a valid/ready handshake and are of two kinds: store a cell that is arriving, or read out a stored cell for transmission.

A store issues the store command, then a header read-back command. If the requester asked for it and the header is sound, a header write command follows. The memory reports a corrupt cell header through an active-low flag, sampled in the data cycle of the store command. Such a cell is not queued. The sequencer reports it as a discard, so that the queue logic returns its buffer address to the free list, and it adds one to an error counter. A read-out issues the transmit command, and the cell address follows on the data bus one cycle later. Each finished request produces a one-cycle completion report carrying the address, the kind, the discard flag and the header that was read back.

Top module: `cellmem_cmd_seq`

## Requirements
- R1: After reset, `req_ready` is 1, `cmd_o` is NOP (6'h00), `dbus_oe` is 0, `done_valid` is 0 and `err_count` is 0.
- R2: A store request (`req_kind` = 0) accepted at a clock edge drives STORE (6'h01) on `cmd_o` in the next cycle and HDR_RD (6'h02) in the cycle after that.
- R3: In the cycle after STORE, `dbus_oe` is 1 and `dbus_out` carries the request address, zero-extended to the bus width.
- R4: `dbus_oe` is 1 only in cycles in which the sequencer drives data. It is 0 while idle, during a command-only cycle, and in the cycle after HDR_RD, when the memory returns the header.
- R5: The value on `dbus_in` in the cycle after HDR_RD is registered and reported on `done_hdr` with the completion of that store.
- R6: When `req_hdr_mod` was 1 at acceptance and no header error was seen, HDR_WR (6'h03) is driven in the cycle after HDR_RD. In the cycle after HDR_WR, the `req_hdr` value captured at acceptance is driven with `dbus_oe` = 1.
- R7: If `hdr_err_n` is 0 in the data cycle of STORE, no HDR_WR is issued (the cycle after HDR_RD shows NOP). The completion carries `done_discard` = 1 and the cell address, and `err_count` rises by one at the same edge.
- R8: `err_count` saturates at its all-ones value and does not wrap.
- R9: A read-out request (`req_kind` = 1) drives XMIT (6'h04) in the cycle after acceptance. In the following cycle it drives NOP, with the address on `dbus_out` and `dbus_oe` = 1.
- R10: `req_ready` is 0 from the edge that accepts a request until the last data cycle of that request has ended. A request held valid during that time is neither issued nor lost: it is accepted once `req_ready` returns.
- R11: `done_valid` pulses for exactly one cycle at the edge that ends the last cycle of a request, with `done_kind` and `done_addr` equal to the accepted request. While `req_valid` is 0 and the block is idle, `cmd_o` stays NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request accepted this edge if valid |
| req_kind | input | 1 | 0 = store, 1 = read-out |
| req_addr | input | ADDR_W | Cell buffer address |
| req_hdr_mod | input | 1 | Store only: write a modified header |
| req_hdr | input | DATA_W | Replacement header for a modified store |
| cmd_o | output | 6 | Command to the cell memory |
| dbus_out | output | DATA_W | Data driven toward the memory |
| dbus_oe | output | 1 | Drive enable for `dbus_out` |
| dbus_in | input | DATA_W | Data returned by the memory |
| hdr_err_n | input | 1 | Active-low header error from the memory |
| done_valid | output | 1 | One-cycle completion pulse |
| done_kind | output | 1 | Kind of the completed request |
| done_discard | output | 1 | Store dropped because of a header error |
| done_addr | output | ADDR_W | Address of the completed request |
| done_hdr | output | DATA_W | Header read back during the store |
| err_count | output | CNT_W | Saturating count of header errors |

## Verification
On every cycle, the assertions check the command-to-data ordering: STORE is followed by HDR_RD with the drive enable up, HDR_RD is followed by an undriven cycle, HDR_WR and XMIT are each followed by a driven data cycle, and the drive enable stays down while idle. They also check that an accepted request drops `req_ready`, and that the error counter moves only on a discard and by exactly one step. Only the bench scenarios can show the values themselves: the address and replacement header on the bus, the captured read-back header, the suppression of the header write after an error, saturation of a narrow counter, and a request held during a busy store that is issued afterwards with its own address.

// File: rtl/cms_pkg.sv
package cms_pkg;

   localparam int CMD_W = 6;

   localparam logic [CMD_W-1:0] CMD_NOP    = 6'h00;
   localparam logic [CMD_W-1:0] CMD_STORE  = 6'h01;
   localparam logic [CMD_W-1:0] CMD_HDR_RD = 6'h02;
   localparam logic [CMD_W-1:0] CMD_HDR_WR = 6'h03;
   localparam logic [CMD_W-1:0] CMD_XMIT   = 6'h04;

   typedef enum logic [2:0] {
      SQ_IDLE   = 3'd0,
      SQ_ST_CMD = 3'd1,
      SQ_ST_HRD = 3'd2,
      SQ_ST_RBK = 3'd3,
      SQ_ST_WDT = 3'd4,
      SQ_XM_CMD = 3'd5,
      SQ_XM_DAT = 3'd6
   } seq_state_t;

   localparam logic KIND_STORE = 1'b0;
   localparam logic KIND_XMIT  = 1'b1;

endpackage

// File: rtl/cms_fsm.sv
module cms_fsm
   import cms_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_valid,
   input  logic       req_kind,
   input  logic       wr_hdr,
   output seq_state_t state,
   output logic       accept,
   output logic       last_cyc
);

   seq_state_t state_nx;

   assign accept = (state == SQ_IDLE) && req_valid;

   assign last_cyc = ((state == SQ_ST_RBK) && !wr_hdr) ||
                     (state == SQ_ST_WDT) ||
                     (state == SQ_XM_DAT);

   always_comb begin
      state_nx = state;
      unique case (state)
         SQ_IDLE: begin
            if (req_valid) begin
               state_nx = (req_kind == KIND_XMIT) ? SQ_XM_CMD : SQ_ST_CMD;
            end
         end
         SQ_ST_CMD: state_nx = SQ_ST_HRD;
         SQ_ST_HRD: state_nx = SQ_ST_RBK;
         SQ_ST_RBK: state_nx = wr_hdr ? SQ_ST_WDT : SQ_IDLE;
         SQ_ST_WDT: state_nx = SQ_IDLE;
         SQ_XM_CMD: state_nx = SQ_XM_DAT;
         SQ_XM_DAT: state_nx = SQ_IDLE;
         default:   state_nx = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= SQ_IDLE;
      end else begin
         state <= state_nx;
      end
   end

endmodule

// File: rtl/cms_errcnt.sv
module cms_errcnt #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   output logic [W-1:0] count
);

   localparam logic [W-1:0] TOP = {W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (inc && (count != TOP)) begin
         count <= count + 1'b1;
      end
   end

endmodule

// File: rtl/cms_dpath.sv
module cms_dpath
   import cms_pkg::*;
#(
   parameter int ADDR_W     = 13,
   parameter int DATA_W     = 32,
   parameter bit HDR_MOD_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  seq_state_t        state,
   input  logic              accept,
   input  logic              last_cyc,
   input  logic              req_kind,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_hdr_mod,
   input  logic [DATA_W-1:0] req_hdr,
   input  logic [DATA_W-1:0] dbus_in,
   input  logic              hdr_err_n,
   output logic              wr_hdr,
   output logic              err_inc,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] newhdr_q,
   output logic              done_valid,
   output logic              done_kind,
   output logic              done_discard,
   output logic [ADDR_W-1:0] done_addr,
   output logic [DATA_W-1:0] done_hdr
);

   logic              kind_q;
   logic              mod_q;
   logic              err_q;
   logic [DATA_W-1:0] rbk_q;

   generate
      if (HDR_MOD_EN) begin : g_mod
         assign wr_hdr = mod_q && !err_q;
      end else begin : g_nomod
         assign wr_hdr = 1'b0;
      end
   endgenerate

   assign err_inc = (state == SQ_ST_RBK) && err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q   <= '0;
         newhdr_q <= '0;
         kind_q   <= KIND_STORE;
         mod_q    <= 1'b0;
      end else if (accept) begin
         addr_q   <= req_addr;
         newhdr_q <= req_hdr;
         kind_q   <= req_kind;
         mod_q    <= req_hdr_mod && (req_kind == KIND_STORE);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_q <= 1'b0;
      end else if (accept) begin
         err_q <= 1'b0;
      end else if (state == SQ_ST_HRD) begin
         err_q <= !hdr_err_n;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rbk_q <= '0;
      end else if (state == SQ_ST_RBK) begin
         rbk_q <= dbus_in;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_valid   <= 1'b0;
         done_kind    <= KIND_STORE;
         done_discard <= 1'b0;
         done_addr    <= '0;
         done_hdr     <= '0;
      end else begin
         done_valid <= last_cyc;
         if (last_cyc) begin
            done_kind    <= kind_q;
            done_discard <= (kind_q == KIND_STORE) && err_q;
            done_addr    <= addr_q;
            done_hdr     <= (state == SQ_ST_RBK) ? dbus_in : rbk_q;
         end
      end
   end

endmodule

// File: rtl/cms_bus.sv
module cms_bus
   import cms_pkg::*;
#(
   parameter int ADDR_W = 13,
   parameter int DATA_W = 32
) (
   input  seq_state_t        state,
   input  logic              wr_hdr,
   input  logic [ADDR_W-1:0] addr_q,
   input  logic [DATA_W-1:0] newhdr_q,
   output logic [CMD_W-1:0]  cmd_o,
   output logic [DATA_W-1:0] dbus_out,
   output logic              dbus_oe
);

   localparam int PAD_W = DATA_W - ADDR_W;

   logic [DATA_W-1:0] addr_ext;

   generate
      if (PAD_W == 0) begin : g_nopad
         assign addr_ext = addr_q;
      end else begin : g_pad
         assign addr_ext = {{PAD_W{1'b0}}, addr_q};
      end
   endgenerate

   always_comb begin
      cmd_o    = CMD_NOP;
      dbus_out = '0;
      dbus_oe  = 1'b0;
      unique case (state)
         SQ_ST_CMD: cmd_o = CMD_STORE;
         SQ_ST_HRD: begin
            cmd_o    = CMD_HDR_RD;
            dbus_out = addr_ext;
            dbus_oe  = 1'b1;
         end
         SQ_ST_RBK: cmd_o = wr_hdr ? CMD_HDR_WR : CMD_NOP;
         SQ_ST_WDT: begin
            dbus_out = newhdr_q;
            dbus_oe  = 1'b1;
         end
         SQ_XM_CMD: cmd_o = CMD_XMIT;
         SQ_XM_DAT: begin
            dbus_out = addr_ext;
            dbus_oe  = 1'b1;
         end
         default: cmd_o = CMD_NOP;
      endcase
   end

endmodule

// File: rtl/cellmem_cmd_seq.sv
module cellmem_cmd_seq
   import cms_pkg::*;
#(
   parameter int ADDR_W     = 13,
   parameter int DATA_W     = 32,
   parameter int CNT_W      = 16,
   parameter bit HDR_MOD_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_kind,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_hdr_mod,
   input  logic [DATA_W-1:0] req_hdr,
   output logic [5:0]        cmd_o,
   output logic [DATA_W-1:0] dbus_out,
   output logic              dbus_oe,
   input  logic [DATA_W-1:0] dbus_in,
   input  logic              hdr_err_n,
   output logic              done_valid,
   output logic              done_kind,
   output logic              done_discard,
   output logic [ADDR_W-1:0] done_addr,
   output logic [DATA_W-1:0] done_hdr,
   output logic [CNT_W-1:0]  err_count
);

   generate
      if (ADDR_W < 1 || ADDR_W > DATA_W) begin : g_bad_addr
         $error("cellmem_cmd_seq: ADDR_W must be 1..DATA_W");
      end
      if (DATA_W < 8) begin : g_bad_data
         $error("cellmem_cmd_seq: DATA_W must be at least 8");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("cellmem_cmd_seq: CNT_W must be positive");
      end
   endgenerate

   seq_state_t        state;
   logic              accept;
   logic              last_cyc;
   logic              wr_hdr;
   logic              err_inc;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] newhdr_q;

   assign req_ready = (state == SQ_IDLE);

   cms_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_kind  (req_kind),
      .wr_hdr    (wr_hdr),
      .state     (state),
      .accept    (accept),
      .last_cyc  (last_cyc)
   );

   cms_dpath #(
      .ADDR_W     (ADDR_W),
      .DATA_W     (DATA_W),
      .HDR_MOD_EN (HDR_MOD_EN)
   ) u_dpath (
      .clk          (clk),
      .rst_n        (rst_n),
      .state        (state),
      .accept       (accept),
      .last_cyc     (last_cyc),
      .req_kind     (req_kind),
      .req_addr     (req_addr),
      .req_hdr_mod  (req_hdr_mod),
      .req_hdr      (req_hdr),
      .dbus_in      (dbus_in),
      .hdr_err_n    (hdr_err_n),
      .wr_hdr       (wr_hdr),
      .err_inc      (err_inc),
      .addr_q       (addr_q),
      .newhdr_q     (newhdr_q),
      .done_valid   (done_valid),
      .done_kind    (done_kind),
      .done_discard (done_discard),
      .done_addr    (done_addr),
      .done_hdr     (done_hdr)
   );

   cms_bus #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_bus (
      .state    (state),
      .wr_hdr   (wr_hdr),
      .addr_q   (addr_q),
      .newhdr_q (newhdr_q),
      .cmd_o    (cmd_o),
      .dbus_out (dbus_out),
      .dbus_oe  (dbus_oe)
   );

   cms_errcnt #(
      .W (CNT_W)
   ) u_errcnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (err_inc),
      .count (err_count)
   );

endmodule

// File: rtl/cms_chk.sv
module cms_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_ready,
   input logic [5:0]       cmd_o,
   input logic             dbus_oe,
   input logic             done_valid,
   input logic             done_kind,
   input logic             done_discard,
   input logic [CNT_W-1:0] err_count
);

   localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

   AST_STORE_THEN_HRD: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_o == 6'h01 |=> (cmd_o == 6'h02) && dbus_oe); // R2

   AST_STORE_CMD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_o == 6'h01 |-> !dbus_oe); // R3

   AST_RBK_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_o == 6'h02 |=> !dbus_oe); // R4

   AST_IDLE_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !dbus_oe); // R4

   AST_HWR_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_o == 6'h03 |=> dbus_oe && (cmd_o == 6'h00)); // R6

   AST_XMIT_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_o == 6'h04 |=> dbus_oe && (cmd_o == 6'h00)); // R9

   AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> !req_ready); // R10

   AST_CNT_ONLY_ON_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_valid && done_discard) |-> $stable(err_count)); // R7

   AST_DISCARD_IS_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid && done_discard |-> !done_kind); // R7

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid && done_discard && ($past(err_count) != TOP)
      |-> err_count == $past(err_count) + 1'b1); // R8

   AST_CNT_HOLD_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      $past(err_count) == TOP |-> err_count == TOP); // R8

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |=> !done_valid); // R11

endmodule

bind cellmem_cmd_seq cms_chk #(
   .CNT_W (CNT_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .req_ready    (req_ready),
   .cmd_o        (cmd_o),
   .dbus_oe      (dbus_oe),
   .done_valid   (done_valid),
   .done_kind    (done_kind),
   .done_discard (done_discard),
   .err_count    (err_count)
);

// File: tb/cellmem_cmd_seq_tb.sv
module cellmem_cmd_seq_tb;

   localparam int AW = 13;
   localparam int DW = 32;
   localparam int CW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic          req_kind = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic          req_hdr_mod = 1'b0;
   logic [DW-1:0] req_hdr = '0;
   logic [5:0]    cmd_o;
   logic [DW-1:0] dbus_out;
   logic          dbus_oe;
   logic [DW-1:0] dbus_in = '0;
   logic          hdr_err_n = 1'b1;
   logic          done_valid;
   logic          done_kind;
   logic          done_discard;
   logic [AW-1:0] done_addr;
   logic [DW-1:0] done_hdr;
   logic [CW-1:0] err_count;

   int vectors = 0;
   int fails   = 0;
   int exp_err = 0;
   bit over    = 1'b0;

   always #10 clk = ~clk;

   cellmem_cmd_seq #(
      .ADDR_W (AW), .DATA_W (DW), .CNT_W (CW), .HDR_MOD_EN (1'b1)
   ) u_dut (
      .clk (clk), .rst_n (rst_n),
      .req_valid (req_valid), .req_ready (req_ready), .req_kind (req_kind),
      .req_addr (req_addr), .req_hdr_mod (req_hdr_mod), .req_hdr (req_hdr),
      .cmd_o (cmd_o), .dbus_out (dbus_out), .dbus_oe (dbus_oe),
      .dbus_in (dbus_in), .hdr_err_n (hdr_err_n),
      .done_valid (done_valid), .done_kind (done_kind),
      .done_discard (done_discard), .done_addr (done_addr),
      .done_hdr (done_hdr), .err_count (err_count)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   endtask

   // Store scenario. Entered at a negedge with the block idle.
   // hold: keep a read-out request (addr hold_addr) valid during the store.
   task automatic run_store(input logic [AW-1:0] a, input bit mod,
                            input logic [DW-1:0] nh, input logic [DW-1:0] mh,
                            input bit err, input bit hold,
                            input logic [AW-1:0] hold_addr);
      bit wr;
      wr = mod && !err;
      req_valid = 1'b1; req_kind = 1'b0; req_addr = a;
      req_hdr_mod = mod; req_hdr = nh;
      @(posedge clk);
      @(negedge clk);
      if (hold) begin
         req_kind = 1'b1; req_addr = hold_addr; req_hdr_mod = 1'b0;
      end else begin
         req_valid = 1'b0;
      end
      chk("R2 store cmd", cmd_o, 6'h01);
      chk("R10 ready low", req_ready, 1'b0);
      chk("R4 oe in command cycle", dbus_oe, 1'b0);
      @(negedge clk);
      chk("R2 header read cmd", cmd_o, 6'h02);
      chk("R3 oe", dbus_oe, 1'b1);
      chk("R3 address on bus", dbus_out, {{(DW-AW){1'b0}}, a});
      hdr_err_n = !err;
      @(negedge clk);
      hdr_err_n = 1'b1;
      chk(err ? "R7 no header write" : "R6 header write choice",
          cmd_o, wr ? 6'h03 : 6'h00);
      chk("R4 oe low in read-back", dbus_oe, 1'b0);
      chk("R10 ready low", req_ready, 1'b0);
      dbus_in = mh;
      @(negedge clk);
      dbus_in = '0;
      if (wr) begin
         chk("R6 data cmd nop", cmd_o, 6'h00);
         chk("R6 oe", dbus_oe, 1'b1);
         chk("R6 new header", dbus_out, nh);
         chk("R10 ready low", req_ready, 1'b0);
         chk("R11 no early done", done_valid, 1'b0);
         @(negedge clk);
      end
      if (err && exp_err < (1 << CW) - 1) exp_err++;
      chk("R11 done", done_valid, 1'b1);
      chk("R11 done kind", done_kind, 1'b0);
      chk("R11 done addr", done_addr, a);
      chk("R7 discard flag", done_discard, err);
      chk("R5 read-back header", done_hdr, mh);
      chk(err ? "R7 error count" : "R8 count unchanged", err_count, exp_err);
      chk("R10 ready back", req_ready, 1'b1);
   endtask

   // Read-out after acceptance edge; entered at the negedge after acceptance.
   task automatic xmit_tail(input logic [AW-1:0] a);
      chk("R9 xmit cmd", cmd_o, 6'h04);
      chk("R4 oe in xmit cycle", dbus_oe, 1'b0);
      chk("R10 ready low", req_ready, 1'b0);
      @(negedge clk);
      chk("R9 nop with data", cmd_o, 6'h00);
      chk("R9 oe", dbus_oe, 1'b1);
      chk("R9 address on bus", dbus_out, {{(DW-AW){1'b0}}, a});
      @(negedge clk);
      chk("R11 done", done_valid, 1'b1);
      chk("R11 done kind", done_kind, 1'b1);
      chk("R11 done addr", done_addr, a);
      chk("R11 no discard", done_discard, 1'b0);
      chk("R10 ready back", req_ready, 1'b1);
   endtask

   task automatic run_xmit(input logic [AW-1:0] a);
      req_valid = 1'b1; req_kind = 1'b1; req_addr = a; req_hdr_mod = 1'b0;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      xmit_tail(a);
   endtask

   task automatic idle_check(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         chk("R11 idle nop", cmd_o, 6'h00);
         chk("R4 idle oe", dbus_oe, 1'b0);
         chk("R11 no done", done_valid, 1'b0);
      end
   endtask

   task automatic busy_hold();
      run_store(13'h0A5, 1'b1, 32'h1111_2222, 32'h3333_4444, 1'b0, 1'b1, 13'h1F0);
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      xmit_tail(13'h1F0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 ready", req_ready, 1'b1);
      chk("R1 cmd", cmd_o, 6'h00);
      chk("R1 oe", dbus_oe, 1'b0);
      chk("R1 done", done_valid, 1'b0);
      chk("R1 count", err_count, 0);
      rst_n = 1'b1;
      idle_check(3);
      run_store(13'h012, 1'b0, 32'h0, 32'hDEAD_BEEF, 1'b0, 1'b0, '0);
      run_store(13'h1FFF, 1'b1, 32'hCAFE_0001, 32'h0BAD_F00D, 1'b0, 1'b0, '0);
      run_xmit(13'h0777);
      run_store(13'h0042, 1'b1, 32'h5555_AAAA, 32'h1234_5678, 1'b1, 1'b0, '0);
      run_xmit(13'h0000);
      busy_hold();
      idle_check(2);
      for (int i = 0; i < 8; i++) begin
         run_store(AW'(i + 100), i[0], 32'hF0F0_0000 + i, 32'h0000_0F00 + i,
                   1'b1, 1'b0, '0);
      end
      chk("R8 saturated", err_count, 3'd7);
      run_store(13'h0333, 1'b1, 32'hABCD_EF01, 32'h7777_8888, 1'b0, 1'b0, '0);
      idle_check(2);
      over = 1'b1;
      summary();
   end

   initial begin
      for (int c = 0; c < 20000; c++) begin
         @(posedge clk);
         if (over) break;
      end
      if (!over) begin
         vectors++;
         fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         summary();
      end
   end

endmodule